// File: doc/BRIEF.md
# Hex Record Command Parser

This block sits behind a UART receiver and turns a stream of ASCII characters into decoded command records. Each record opens with a colon and then carries ASCII hex digit pairs: a byte count, a two-byte address, a record type, up to sixteen payload bytes and a closing checksum byte. The parser converts each digit pair into a byte, keeps a running 8-bit sum and stores the payload in a small buffer. It acts on nothing until the last checksum digit has arrived.

When a record completes with a good checksum, the parser either raises a one-cycle command strobe with the decoded type, address, length and payload, or refuses the record. Every record gets exactly one ASCII reply byte: a dot for success, `X` for a malformed record or bad checksum, and `R` for a refused or failed data record. Data records (type 00h) are passed downstream for programming only after a clock-frequency record (type 02h) has been accepted. The parser then waits for a program-result handshake and replies according to that result. The trailing CR LF, and any other characters between records, are dropped while the parser waits for the next colon.

Top module: `hexrec_parser`

## Requirements
- R1: While waiting for a record, every character other than a colon (3Ah) is discarded: it produces no reply and no command strobe.
- R2: Hex digits 0-9, A-F and a-f are accepted. Each byte is formed from two digits, the first digit being the high nibble.
- R3: If the count byte is above 16, the record is aborted with a single `X` reply (58h), and the parser goes back to waiting for a colon. Strobed lengths never exceed 16.
- R4: A character that is not a hex digit, arriving anywhere after the colon and before the last checksum digit, aborts the record with a single `X` reply.
- R5: A record is good only when the 8-bit sum of count, address high, address low, type, all payload bytes and the checksum is zero. Otherwise the reply is `X` and no strobe is raised.
- R6: No strobe is raised before the final checksum digit. The strobe `cmd_valid` lasts one cycle and presents the type, the 16-bit address (first address byte high), the count, and payload byte i in `cmd_data[8i+7:8i]`.
- R7: A good type 00h record received before any accepted type 02h record is refused with reply `R` (52h) and no strobe.
- R8: A good type 02h record raises the strobe and replies with a dot (2Eh). From then until reset, data records are accepted.
- R9: An accepted type 00h record raises the strobe and then waits for `prog_done`. The reply is a dot if `prog_ok` is high in that cycle and `R` if it is low.
- R10: A good type 01h (end of file) record replies with a dot and raises no strobe.
- R11: Any other good record type (for example 03h or 05h, whose subfunction and selection codes are payload bytes 0 and 1) raises the strobe and replies with a dot.
- R12: Each record that starts with a colon yields exactly one reply byte, and that byte is always a dot, `X` or `R`.
- R13: After reset, no reply and no strobe are raised, and data records are refused until a type 02h record is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received character valid |
| rx_byte | input | 8 | Received ASCII character |
| prog_done | input | 1 | Programming of the strobed data record finished |
| prog_ok | input | 1 | Programming result, sampled with prog_done |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_type | output | 8 | Decoded record type |
| cmd_addr | output | 16 | Decoded record address |
| cmd_len | output | 5 | Decoded payload byte count |
| cmd_data | output | 128 | Payload bytes, byte i at bits 8i+7:8i |
| resp_valid | output | 1 | Reply byte valid |
| resp_byte | output | 8 | ASCII reply byte |

## Verification
A wrong nibble phase or byte index shows up at the ports as a shifted address or payload, or as a checksum miss. Either appears within the next record, as a wrong `X` reply or as bad strobed fields. A stale frequency flag shows up at once as an `R` reply, or as a strobe on the first data record. A broken wait-for-result state shows up either as a missing reply or as a reply sent before `prog_done`. Random records, some with corrupted checksums and mixed-case digits, are checked against a bench model of the reply and strobe rules. Directed cases cover oversized counts, illegal characters, noise between records and the order of frequency and data records.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
  localparam logic [7:0] ASC_COLON = 8'h3A;
  localparam logic [7:0] ASC_DOT   = 8'h2E;
  localparam logic [7:0] ASC_X     = 8'h58;
  localparam logic [7:0] ASC_R     = 8'h52;

  localparam logic [7:0] TYP_DATA  = 8'h00;
  localparam logic [7:0] TYP_EOF   = 8'h01;
  localparam logic [7:0] TYP_FREQ  = 8'h02;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_BODY = 2'd1,
    ST_EXEC = 2'd2,
    ST_PROG = 2'd3
  } pstate_t;
endpackage

// File: rtl/hexrec_nibble.sv
module hexrec_nibble (
  input  logic [7:0] ch,
  output logic       is_hex,
  output logic [3:0] nib
);
  always_comb begin
    is_hex = 1'b1;
    nib    = 4'h0;
    if (ch >= 8'h30 && ch <= 8'h39)      nib = 4'(ch - 8'h30);
    else if (ch >= 8'h41 && ch <= 8'h46) nib = 4'(ch - 8'h37);
    else if (ch >= 8'h61 && ch <= 8'h66) nib = 4'(ch - 8'h57);
    else                                 is_hex = 1'b0;
  end
endmodule

// File: rtl/hexrec_assembler.sv
module hexrec_assembler #(
  parameter int IDXW    = 5,
  parameter int IDX_MAX = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            nib_stb,
  input  logic [3:0]      nib,
  output logic            byte_stb,
  output logic [7:0]      byte_val,
  output logic [IDXW-1:0] byte_idx,
  output logic            sum_zero
);
  logic            phase_q, phase_d;
  logic [3:0]      hi_q, hi_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [7:0]      sum_q, sum_d;

  assign byte_stb = nib_stb & phase_q;
  assign byte_val = {hi_q, nib};
  assign byte_idx = idx_q;
  assign sum_zero = ((sum_q + byte_val) == 8'h00);

  always_comb begin
    phase_d = phase_q;
    hi_d    = hi_q;
    idx_d   = idx_q;
    sum_d   = sum_q;
    if (clr) begin
      phase_d = 1'b0;
      hi_d    = 4'h0;
      idx_d   = '0;
      sum_d   = 8'h00;
    end else if (nib_stb) begin
      if (!phase_q) begin
        hi_d    = nib;
        phase_d = 1'b1;
      end else begin
        phase_d = 1'b0;
        idx_d   = idx_q + IDXW'(1);
        sum_d   = sum_q + byte_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hi_q    <= 4'h0;
      idx_q   <= '0;
      sum_q   <= 8'h00;
    end else begin
      phase_q <= phase_d;
      hi_q    <= hi_d;
      idx_q   <= idx_d;
      sum_q   <= sum_d;
    end
  end

  // R3: oversized counts abort, so no byte index passes the checksum slot
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> (byte_idx <= IDXW'(IDX_MAX)));
  // R2: a completed byte leaves the next digit as a high nibble
  p_pair_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && !clr) |=> !phase_q);
endmodule

// File: rtl/hexrec_databuf.sv
module hexrec_databuf #(
  parameter int MAX_DATA = 16,
  parameter int WBW      = $clog2(MAX_DATA)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WBW-1:0]        wr_idx,
  input  logic [7:0]            wr_byte,
  output logic [MAX_DATA*8-1:0] data_flat
);
  for (genvar g = 0; g < MAX_DATA; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q <= 8'h00;
      else if (wr_en && wr_idx == WBW'(g))     slot_q <= wr_byte;
    end
    assign data_flat[g*8 +: 8] = slot_q;
  end
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser #(
  parameter int MAX_DATA = 16,
  parameter int LENW     = $clog2(MAX_DATA + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_byte,
  input  logic                  prog_done,
  input  logic                  prog_ok,
  output logic                  cmd_valid,
  output logic [7:0]            cmd_type,
  output logic [15:0]           cmd_addr,
  output logic [LENW-1:0]       cmd_len,
  output logic [MAX_DATA*8-1:0] cmd_data,
  output logic                  resp_valid,
  output logic [7:0]            resp_byte
);
  import hexrec_pkg::*;

  localparam int HDR     = 4;
  localparam int IDX_MAX = MAX_DATA + HDR;
  localparam int IDXW    = $clog2(IDX_MAX + 1);
  localparam int WBW     = $clog2(MAX_DATA);

  pstate_t         state_q, state_d;
  logic [LENW-1:0] len_q;
  logic [15:0]     addr_q;
  logic [7:0]      type_q;
  logic            freq_q, freq_set;
  logic            sum_ok_q;
  logic            cmd_q, cmd_set;
  logic            resp_q, resp_set;
  logic [7:0]      resp_code_q, resp_code;

  logic            is_hex;
  logic [3:0]      nib;
  logic            asm_clr, nib_stb;
  logic            byte_stb, sum_zero;
  logic [7:0]      byte_val;
  logic [IDXW-1:0] byte_idx;
  logic            last_byte, hdr_len_bad, buf_wr;
  logic [IDXW-1:0] data_rel;

  hexrec_nibble u_nib (
    .ch     (rx_byte),
    .is_hex (is_hex),
    .nib    (nib)
  );

  assign asm_clr = (state_q == ST_HUNT) && rx_valid && (rx_byte == ASC_COLON);
  assign nib_stb = (state_q == ST_BODY) && rx_valid && is_hex;

  hexrec_assembler #(.IDXW(IDXW), .IDX_MAX(IDX_MAX)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (asm_clr),
    .nib_stb  (nib_stb),
    .nib      (nib),
    .byte_stb (byte_stb),
    .byte_val (byte_val),
    .byte_idx (byte_idx),
    .sum_zero (sum_zero)
  );

  assign hdr_len_bad = byte_stb && (byte_idx == '0) && (byte_val > 8'(MAX_DATA));
  assign last_byte   = byte_stb && (byte_idx >= IDXW'(HDR)) &&
                       (byte_idx == IDXW'(len_q) + IDXW'(HDR));
  assign data_rel    = byte_idx - IDXW'(HDR);
  assign buf_wr      = byte_stb && (byte_idx >= IDXW'(HDR)) && !last_byte;

  hexrec_databuf #(.MAX_DATA(MAX_DATA), .WBW(WBW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (buf_wr),
    .wr_idx    (data_rel[WBW-1:0]),
    .wr_byte   (byte_val),
    .data_flat (cmd_data)
  );

  // next-state and action decode
  always_comb begin
    state_d   = state_q;
    resp_set  = 1'b0;
    resp_code = ASC_DOT;
    cmd_set   = 1'b0;
    freq_set  = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (asm_clr) state_d = ST_BODY;
      end
      ST_BODY: begin
        if (rx_valid) begin
          if (!is_hex || hdr_len_bad) begin
            resp_set  = 1'b1;
            resp_code = ASC_X;
            state_d   = ST_HUNT;
          end else if (last_byte) begin
            state_d = ST_EXEC;
          end
        end
      end
      ST_EXEC: begin
        state_d = ST_HUNT;
        if (!sum_ok_q) begin
          resp_set  = 1'b1;
          resp_code = ASC_X;
        end else if (type_q == TYP_DATA) begin
          if (!freq_q) begin
            resp_set  = 1'b1;
            resp_code = ASC_R;
          end else begin
            cmd_set = 1'b1;
            state_d = ST_PROG;
          end
        end else if (type_q == TYP_EOF) begin
          resp_set = 1'b1;
        end else begin
          cmd_set  = 1'b1;
          resp_set = 1'b1;
          freq_set = (type_q == TYP_FREQ);
        end
      end
      ST_PROG: begin
        if (prog_done) begin
          resp_set  = 1'b1;
          resp_code = prog_ok ? ASC_DOT : ASC_R;
          state_d   = ST_HUNT;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_HUNT;
      len_q       <= '0;
      addr_q      <= 16'h0000;
      type_q      <= 8'h00;
      freq_q      <= 1'b0;
      sum_ok_q    <= 1'b0;
      cmd_q       <= 1'b0;
      resp_q      <= 1'b0;
      resp_code_q <= 8'h00;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_set;
      resp_q  <= resp_set;
      if (resp_set) resp_code_q <= resp_code;
      if (freq_set) freq_q <= 1'b1;
      if (last_byte) sum_ok_q <= sum_zero;
      if (byte_stb && !hdr_len_bad) begin
        if (byte_idx == IDXW'(0)) len_q         <= byte_val[LENW-1:0];
        if (byte_idx == IDXW'(1)) addr_q[15:8]  <= byte_val;
        if (byte_idx == IDXW'(2)) addr_q[7:0]   <= byte_val;
        if (byte_idx == IDXW'(3)) type_q        <= byte_val;
      end
    end
  end

  assign cmd_valid  = cmd_q;
  assign cmd_type   = type_q;
  assign cmd_addr   = addr_q;
  assign cmd_len    = len_q;
  assign resp_valid = resp_q;
  assign resp_byte  = resp_code_q;

  // R6: the strobe lasts a single cycle and only follows a completed record
  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_strobe_after_check_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(state_q) == ST_EXEC));
  // R3: strobed length never exceeds the payload limit
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len <= LENW'(MAX_DATA)));
  // R12: reply codes are restricted to the three ASCII characters
  p_reply_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_byte == ASC_DOT || resp_byte == ASC_X || resp_byte == ASC_R));
  // R7: a data record is only strobed once a frequency record was accepted
  p_data_needs_freq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == TYP_DATA) |-> freq_q);
  // R5: a checksum miss replies X with no strobe
  p_bad_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && !sum_ok_q) |=> (resp_valid && resp_byte == ASC_X && !cmd_valid));
  // R9: program result yields a reply in the next cycle
  p_prog_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && prog_done) |=> resp_valid);
  // R1: hunting with no colon keeps the block silent next cycle
  p_hunt_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT) |=> !cmd_valid);
endmodule

// File: tb/sim_hexrec_parser.sv
module sim_hexrec_parser;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_byte = 8'h00;
  logic         prog_done = 1'b0;
  logic         prog_ok = 1'b0;
  logic         cmd_valid;
  logic [7:0]   cmd_type;
  logic [15:0]  cmd_addr;
  logic [4:0]   cmd_len;
  logic [127:0] cmd_data;
  logic         resp_valid;
  logic [7:0]   resp_byte;

  hexrec_parser u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .prog_done(prog_done), .prog_ok(prog_ok), .cmd_valid(cmd_valid),
    .cmd_type(cmd_type), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_data(cmd_data), .resp_valid(resp_valid), .resp_byte(resp_byte)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int resp_cnt = 0;
  int cmd_cnt = 0;
  bit done = 0;
  bit want_ok = 1;
  bit model_freq = 0;
  logic [7:0]   last_resp;
  logic [7:0]   cap_type;
  logic [15:0]  cap_addr;
  logic [4:0]   cap_len;
  logic [127:0] cap_data;
  logic [7:0]   dbuf [0:15];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (resp_valid) begin resp_cnt++; last_resp = resp_byte; end
      if (cmd_valid) begin
        cmd_cnt++;
        cap_type = cmd_type; cap_addr = cmd_addr; cap_len = cmd_len; cap_data = cmd_data;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid && cmd_type == 8'h00) begin
        repeat (3) @(negedge clk);
        prog_done = 1'b1; prog_ok = want_ok;
        @(negedge clk);
        prog_done = 1'b0; prog_ok = 1'b0;
      end
    end
  end

  function automatic logic [7:0] hexc(input logic [3:0] v, input bit lc);
    if (v < 4'd10) return 8'h30 + 8'(v);
    return (lc ? 8'h61 : 8'h41) + 8'(v) - 8'd10;
  endfunction

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_hex(input logic [7:0] b, input bit lc);
    send_char(hexc(b[7:4], lc));
    send_char(hexc(b[3:0], lc));
  endtask

  task automatic send_rec(input logic [7:0] typ, input logic [15:0] adr, input int n,
                          input logic [7:0] cnt, input bit bad_ck, input bit lc);
    logic [7:0] sum;
    sum = cnt + adr[15:8] + adr[7:0] + typ;
    send_char(8'h3A);
    send_hex(cnt, lc); send_hex(adr[15:8], lc); send_hex(adr[7:0], lc); send_hex(typ, lc);
    for (int i = 0; i < n; i++) begin sum = sum + dbuf[i]; send_hex(dbuf[i], lc); end
    sum = 8'h00 - sum;
    if (bad_ck) sum = sum ^ 8'h01;
    send_hex(sum, lc);
    send_char(8'h0D); send_char(8'h0A);
  endtask

  task automatic expect_rec(input string req, input logic [7:0] er, input bit ecmd,
                            input logic [7:0] typ, input logic [15:0] adr, input int n);
    repeat (12) @(negedge clk);
    check(resp_cnt == 1, req, resp_cnt, 1);
    check(last_resp == er, req, int'(last_resp), int'(er));
    check(cmd_cnt == int'(ecmd), req, cmd_cnt, int'(ecmd));
    if (ecmd && cmd_cnt == 1) begin
      check(cap_type == typ && cap_addr == adr && cap_len == 5'(n), req,
            int'({cap_type, cap_addr}), int'({typ, adr}));
      for (int i = 0; i < n; i++)
        check(cap_data[i*8 +: 8] == dbuf[i], req, int'(cap_data[i*8 +: 8]), int'(dbuf[i]));
    end
    resp_cnt = 0; cmd_cnt = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] typ;
    int n, pick;
    bit bad, lc;
    logic [15:0] adr;
    logic [7:0] er;
    bit ecmd;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R13: reset state
    check(resp_valid == 1'b0 && cmd_valid == 1'b0, "R13", int'({resp_valid, cmd_valid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: noise before any colon is ignored
    send_char("Z"); send_char("1"); send_char(8'h0D); send_char(8'h0A);
    repeat (6) @(negedge clk);
    check(resp_cnt == 0 && cmd_cnt == 0, "R1", resp_cnt + cmd_cnt, 0);

    // R7 R13: data before frequency record is refused
    dbuf[0] = 8'hA5; dbuf[1] = 8'h3C;
    send_rec(8'h00, 16'h1234, 2, 8'd2, 0, 0);
    expect_rec("R7", 8'h52, 0, 8'h00, 16'h1234, 2);

    // R5: bad checksum on a frequency record
    dbuf[0] = 8'h10;
    send_rec(8'h02, 16'h0000, 1, 8'd1, 1, 0);
    expect_rec("R5", 8'h58, 0, 8'h02, 16'h0000, 1);

    // R8: frequency record accepted
    send_rec(8'h02, 16'h0000, 1, 8'd1, 0, 0);
    expect_rec("R8", 8'h2E, 1, 8'h02, 16'h0000, 1);
    model_freq = 1;

    // R9 R6 R2: full 16-byte data record, lowercase digits, pass
    for (int i = 0; i < 16; i++) dbuf[i] = 8'(i * 17 + 3);
    want_ok = 1;
    send_rec(8'h00, 16'hBEEF, 16, 8'd16, 0, 1);
    expect_rec("R9", 8'h2E, 1, 8'h00, 16'hBEEF, 16);

    // R9: programming failure
    want_ok = 0;
    send_rec(8'h00, 16'h0080, 3, 8'd3, 0, 0);
    expect_rec("R9", 8'h52, 1, 8'h00, 16'h0080, 3);
    want_ok = 1;

    // R3: oversized count aborts
    send_rec(8'h00, 16'h0000, 0, 8'h11, 0, 0);
    expect_rec("R3", 8'h58, 0, 8'h00, 16'h0000, 0);

    // R4: illegal character mid record
    send_char(8'h3A); send_char("0"); send_char("1"); send_char("G");
    send_char("0"); send_char("0");
    expect_rec("R4", 8'h58, 0, 8'h00, 16'h0000, 0);

    // R10: end of file
    send_rec(8'h01, 16'h0000, 0, 8'd0, 0, 0);
    expect_rec("R10", 8'h2E, 0, 8'h01, 16'h0000, 0);

    // R11: erase command with subfunction and selection
    dbuf[0] = 8'h01; dbuf[1] = 8'h20;
    send_rec(8'h03, 16'h0000, 2, 8'd2, 0, 0);
    expect_rec("R11", 8'h2E, 1, 8'h03, 16'h0000, 2);

    // R12 R5 R6: random records against bench model
    for (int k = 0; k < 60; k++) begin
      pick = $urandom_range(0, 4);
      typ = (pick == 4) ? 8'h05 : 8'(pick);
      n = $urandom_range(0, 16);
      adr = 16'($urandom);
      bad = ($urandom_range(0, 3) == 0);
      lc = $urandom_range(0, 1);
      want_ok = ($urandom_range(0, 2) != 0);
      for (int i = 0; i < 16; i++) dbuf[i] = 8'($urandom);
      send_rec(typ, adr, n, 8'(n), bad, lc);
      if (bad) begin er = 8'h58; ecmd = 0; end
      else if (typ == 8'h00) begin ecmd = 1; er = want_ok ? 8'h2E : 8'h52; end
      else if (typ == 8'h01) begin ecmd = 0; er = 8'h2E; end
      else begin ecmd = 1; er = 8'h2E; end
      expect_rec("R12", er, ecmd, typ, adr, n);
    end

    // R13: reset clears frequency acceptance
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send_rec(8'h00, 16'h0010, 1, 8'd1, 0, 0);
    expect_rec("R13", 8'h52, 0, 8'h00, 16'h0010, 1);

    finish_run();
  end
endmodule